// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core should take next. Edge-type sources are captured into sticky pending bits on a rising edge of their request line. Level-type sources, chosen per source by a parameter, keep no pending bit and request only while their line is high. Each source has its own enable bit, and a global enable gates all of them. The lowest-numbered pending and enabled source wins. The block presents it to the core as a vector index equal to the source number plus one, because index 0 is reserved for reset.

When the core acknowledges the request, the controller clears the global enable and the pending bit of the served source. A return pulse sets the global enable again. Requests then stay masked until the core reports that one more main-program instruction has completed. Software can clear pending bits by writing ones, rewrite the enable bits, and set or clear the global enable at any time. Setting the global enable from inside a handler allows nesting. Clearing it masks the request output in the same cycle as the write.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, irq_o is 0, irq_vec_o is 0, the global enable (gie_o) is 0, every pending bit (flags_o) is 0 and every per-source enable is 0.
- R2: A 0-to-1 change of an edge-type request line sets that source's pending bit (bit i of flags_o for source i) one cycle later. The bit stays set while the source or the global enable is off, until it is cleared by acknowledge or by a write-one-to-clear.
- R3: irq_o is 1 only when a source is both pending and individually enabled, the global enable is 1, and no post-return hold-off is active. A source whose enable bit is 0 is never presented.
- R4: irq_vec_o equals the number of the lowest-numbered requesting source plus one (source 0 gives 1, source 7 gives 8). It is 0 whenever irq_o is 0.
- R5: When ack_i is 1 in a cycle where irq_o is 1, the global enable reads 0 from the next cycle, and the pending bit of the presented source is cleared while the other bits are unchanged. A new rising edge on that source in the same cycle keeps its bit set.
- R6: A cycle with flag_clr_we_i at 1 clears every pending bit whose flag_clr_i bit is 1, taking effect in the next cycle. A rising edge on the same source in that cycle keeps the bit set.
- R7: Level-type sources (sources 6 and 7 by default) never set a pending bit. They request in the same cycle that their line is high and enabled. A level request that drops before the global enable is set causes no interrupt.
- R8: A reti_i pulse sets the global enable from the next cycle. irq_o then stays 0 up to and including the first cycle in which instr_done_i is 1, and may be raised from the cycle after it.
- R9: A cycle with gie_we_i at 1 and gie_i at 0 forces irq_o to 0 in that same cycle, and the global enable reads 0 from the next cycle.
- R10: Setting the global enable by a write with gie_we_i at 1 and gie_i at 1 applies no hold-off: a pending, enabled source is presented in the next cycle, which allows nested interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Request line per source |
| flag_clr_we_i | input | 1 | Write strobe for write-one-to-clear of pending bits |
| flag_clr_i | input | NUM_SRC | Pending bits to clear |
| en_we_i | input | 1 | Write strobe for per-source enables |
| en_i | input | NUM_SRC | New per-source enable value |
| gie_we_i | input | 1 | Write strobe for the global enable |
| gie_i | input | 1 | New global enable value |
| ack_i | input | 1 | Core accepts the presented vector |
| reti_i | input | 1 | Core executed a return from interrupt |
| instr_done_i | input | 1 | A main-program instruction completed |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | VEC_W | Vector index of the presented source |
| flags_o | output | NUM_SRC | Pending bits |
| gie_o | output | 1 | Global enable state |

## Verification
Two functions can meet in one cycle on a single pending bit. A fresh rising edge can arrive in the same cycle as the clear that removes the bit, whether that clear comes from acknowledge or from a write-one-to-clear. The bench raises the request line of source 2 in the very cycle it pulses ack_i, and again in a cycle where it writes a one to that bit. In both cases the bit must read set in the following cycle, which shows that the new event was not lost. For the acknowledge case the global enable must also read cleared.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int unsigned DEF_NUM_SRC = 8;

    // Width of a vector index that covers reset (0) plus every source.
    function automatic int unsigned vec_width(input int unsigned n_src);
        return $clog2(n_src + 1);
    endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic req_i,
    input  logic req_prev_i,
    input  logic flag_q_i,
    input  logic en_i,
    input  logic w1c_i,
    input  logic ack_hit_i,
    output logic flag_d_o,
    output logic pend_o
);

    generate
        if (IS_LEVEL) begin : g_level
            logic unused_lvl;
            assign unused_lvl = ^{req_prev_i, flag_q_i, w1c_i, ack_hit_i};
            assign flag_d_o   = 1'b0;
            assign pend_o     = req_i & en_i;
        end else begin : g_edge
            logic rise;
            assign rise     = req_i & ~req_prev_i;
            // a fresh edge wins over any clear in the same cycle
            assign flag_d_o = rise | (flag_q_i & ~w1c_i & ~ack_hit_i);
            assign pend_o   = flag_q_i & en_i;
        end
    endgenerate

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned VEC_W   = 4
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               any_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [NUM_SRC-1:0] sel_o
);

    always_comb begin
        any_o = 1'b0;
        vec_o = '0;
        sel_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                any_o = 1'b1;
                vec_o = VEC_W'(i + 1);
                sel_o = '0;
                sel_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned              NUM_SRC    = DEF_NUM_SRC,
    parameter logic [NUM_SRC-1:0]       LEVEL_MASK = NUM_SRC'('hC0),
    parameter int unsigned              VEC_W      = vec_width(NUM_SRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               flag_clr_we_i,
    input  logic [NUM_SRC-1:0] flag_clr_i,
    input  logic               en_we_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               gie_we_i,
    input  logic               gie_i,
    input  logic               ack_i,
    input  logic               reti_i,
    input  logic               instr_done_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   irq_vec_o,
    output logic [NUM_SRC-1:0] flags_o,
    output logic               gie_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] req_prev;
        logic               gie;
        logic               holdoff;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [NUM_SRC-1:0] flag_nxt;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] sel;
    logic               any_pend;
    logic [VEC_W-1:0]   enc_vec;
    logic               gie_off_now;
    logic               ack_take;

    // per-source capture, edge or level variant chosen by LEVEL_MASK
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_src_cell #(
            .IS_LEVEL (LEVEL_MASK[i])
        ) u_cell (
            .req_i      (req_i[i]),
            .req_prev_i (st_q.req_prev[i]),
            .flag_q_i   (st_q.flags[i]),
            .en_i       (st_q.en[i]),
            .w1c_i      (flag_clr_we_i & flag_clr_i[i]),
            .ack_hit_i  (ack_take & sel[i]),
            .flag_d_o   (flag_nxt[i]),
            .pend_o     (pend[i])
        );
    end

    irq_prio_enc #(
        .NUM_SRC (NUM_SRC),
        .VEC_W   (VEC_W)
    ) u_enc (
        .pend_i (pend),
        .any_o  (any_pend),
        .vec_o  (enc_vec),
        .sel_o  (sel)
    );

    // a disable write masks the request in its own cycle
    assign gie_off_now = gie_we_i & ~gie_i;
    assign irq_o       = any_pend & st_q.gie & ~st_q.holdoff & ~gie_off_now;
    assign irq_vec_o   = irq_o ? enc_vec : '0;
    assign ack_take    = ack_i & irq_o;
    assign flags_o     = st_q.flags;
    assign gie_o       = st_q.gie;

    always_comb begin
        st_d          = st_q;
        st_d.req_prev = req_i;
        st_d.flags    = flag_nxt;

        if (en_we_i) begin
            st_d.en = en_i;
        end

        if (ack_take) begin
            st_d.gie = 1'b0;
        end else if (reti_i) begin
            st_d.gie = 1'b1;
        end else if (gie_we_i) begin
            st_d.gie = gie_i;
        end

        if (reti_i) begin
            st_d.holdoff = 1'b1;
        end else if (instr_done_i) begin
            st_d.holdoff = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
    parameter int unsigned        NUM_SRC    = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
    parameter int unsigned        VEC_W      = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               flag_clr_we_i,
    input logic               gie_we_i,
    input logic               gie_i,
    input logic               ack_i,
    input logic               reti_i,
    input logic               irq_o,
    input logic [VEC_W-1:0]   irq_vec_o,
    input logic [NUM_SRC-1:0] flags_o,
    input logic               gie_o
);

    // R2
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!flag_clr_we_i && !(ack_i && irq_o)) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    // R4
    vec_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (irq_vec_o != '0));

    // R4
    vec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> (irq_vec_o == '0));

    // R5
    ack_gie_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && irq_o) |=> !gie_o);

    // R7
    level_noflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_o & LEVEL_MASK) == '0);

    // R8
    reti_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reti_i |=> !irq_o);

    // R9
    gie_off_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gie_we_i && !gie_i) |-> !irq_o);

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
    .NUM_SRC    (NUM_SRC),
    .LEVEL_MASK (LEVEL_MASK),
    .VEC_W      (VEC_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flag_clr_we_i (flag_clr_we_i),
    .gie_we_i      (gie_we_i),
    .gie_i         (gie_i),
    .ack_i         (ack_i),
    .reti_i        (reti_i),
    .irq_o         (irq_o),
    .irq_vec_o     (irq_vec_o),
    .flags_o       (flags_o),
    .gie_o         (gie_o)
);

// File: tb/irq_vec_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb_top;

    localparam int N = 8;
    localparam int VW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          fc_we = 1'b0;
    logic [N-1:0]  fc = '0;
    logic          en_we = 1'b0;
    logic [N-1:0]  en = '0;
    logic          g_we = 1'b0;
    logic          g = 1'b0;
    logic          ack = 1'b0;
    logic          reti = 1'b0;
    logic          idone = 1'b0;
    logic          irq;
    logic [VW-1:0] vec;
    logic [N-1:0]  flags;
    logic          gie;

    always #4 clk = ~clk;

    irq_vec_ctrl dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .req_i         (req),
        .flag_clr_we_i (fc_we),
        .flag_clr_i    (fc),
        .en_we_i       (en_we),
        .en_i          (en),
        .gie_we_i      (g_we),
        .gie_i         (g),
        .ack_i         (ack),
        .reti_i        (reti),
        .instr_done_i  (idone),
        .irq_o         (irq),
        .irq_vec_o     (vec),
        .flags_o       (flags),
        .gie_o         (gie)
    );

    typedef struct {
        logic          irq;
        logic [VW-1:0] vec;
        logic          gie;
        logic [N-1:0]  flags;
        string         tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    // monitor: compares one expected item per cycle at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (irq !== e.irq || vec !== e.vec || gie !== e.gie || flags !== e.flags) begin
                n_err++;
                $display("FAIL %s: actual irq=%0b vec=%0d gie=%0b flags=%02h expected irq=%0b vec=%0d gie=%0b flags=%02h",
                         e.tag, irq, vec, gie, flags, e.irq, e.vec, e.gie, e.flags);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // driver: push the expectation for the current cycle, then advance
    task automatic cyc(input string tag, input logic i, input int v,
                       input logic ge, input logic [N-1:0] f);
        exp_t e;
        e.irq = i; e.vec = VW'(v); e.gie = ge; e.flags = f; e.tag = tag;
        sb_q.push_back(e);
        step();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc("R1 reset state", 0, 0, 0, 8'h00);

        req = 8'h08;  cyc("R2 edge not yet", 0, 0, 0, 8'h00);
        req = 8'h00;  cyc("R2 flag set", 0, 0, 0, 8'h08);
        req = 8'h20;  cyc("R2", 0, 0, 0, 8'h08);
        req = 8'h00; en_we = 1; en = 8'hFF;
        cyc("R2 latched while disabled", 0, 0, 0, 8'h28);
        en_we = 0; g_we = 1; g = 1;
        cyc("R3 gie still off", 0, 0, 0, 8'h28);
        g_we = 0;
        cyc("R3 R4 src3 beats src5", 1, 4, 1, 8'h28);

        g_we = 1; g = 0; cyc("R9 masked same cycle", 0, 0, 1, 8'h28);
        g_we = 0;        cyc("R9 gie cleared", 0, 0, 0, 8'h28);
        g_we = 1; g = 1; cyc("R9 re-enable", 0, 0, 0, 8'h28);
        g_we = 0;

        ack = 1; cyc("R5 ack cycle", 1, 4, 1, 8'h28);
        ack = 0; cyc("R5 served bit cleared", 0, 0, 0, 8'h20);

        reti = 1;  cyc("R8 reti cycle", 0, 0, 0, 8'h20);
        reti = 0;  cyc("R8 holdoff", 0, 0, 1, 8'h20);
        cyc("R8 holdoff kept", 0, 0, 1, 8'h20);
        idone = 1; cyc("R8 done cycle", 0, 0, 1, 8'h20);
        idone = 0; cyc("R8 served after one instruction", 1, 6, 1, 8'h20);
        ack = 1;   cyc("R5", 1, 6, 1, 8'h20);
        ack = 0;

        req = 8'h02; cyc("R10", 0, 0, 0, 8'h00);
        req = 8'h00; cyc("R10 pending in handler", 0, 0, 0, 8'h02);
        g_we = 1; g = 1; cyc("R10 nest write", 0, 0, 0, 8'h02);
        g_we = 0;    cyc("R10 nested served at once", 1, 2, 1, 8'h02);

        fc_we = 1; fc = 8'h02; cyc("R6 w1c cycle", 1, 2, 1, 8'h02);
        fc_we = 0; cyc("R6 w1c cleared", 0, 0, 1, 8'h00);
        req = 8'h04; cyc("R6", 0, 0, 1, 8'h00);
        req = 8'h00; cyc("R6 src2 pending", 1, 3, 1, 8'h04);
        req = 8'h04; fc_we = 1; fc = 8'h04;
        cyc("R6 edge with clear", 1, 3, 1, 8'h04);
        req = 8'h00; fc_we = 0;
        cyc("R6 edge beats clear", 1, 3, 1, 8'h04);
        req = 8'h04; ack = 1;
        cyc("R5 edge with ack", 1, 3, 1, 8'h04);
        req = 8'h00; ack = 0;
        cyc("R5 edge during ack kept", 0, 0, 0, 8'h04);
        fc_we = 1; fc = 8'h04; cyc("R6", 0, 0, 0, 8'h04);
        fc_we = 0; cyc("R6 cleared", 0, 0, 0, 8'h00);

        req = 8'h40; cyc("R7 level no flag", 0, 0, 0, 8'h00);
        req = 8'h00; cyc("R7 level gone", 0, 0, 0, 8'h00);
        g_we = 1; g = 1; cyc("R7", 0, 0, 0, 8'h00);
        g_we = 0;    cyc("R7 vanished level no irq", 0, 0, 1, 8'h00);
        req = 8'hC0; cyc("R7 R4 level live", 1, 7, 1, 8'h00);
        req = 8'h80; cyc("R7 src7", 1, 8, 1, 8'h00);
        req = 8'h81; cyc("R7 level with edge", 1, 8, 1, 8'h00);
        req = 8'h80; cyc("R4 src0 beats level", 1, 1, 1, 8'h01);
        en_we = 1; en = 8'hFE; cyc("R3", 1, 1, 1, 8'h01);
        en_we = 0; cyc("R3 masked source skipped", 1, 8, 1, 8'h01);
        req = 8'h00; cyc("R2 R3 latched masked", 0, 0, 1, 8'h01);

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule